// File: doc/BRIEF.md
# Table-driven carry function unit

This unit evaluates a small acyclic integer dataflow subgraph in one pass. The subgraph can mix any number of bitwise logic operations with up to two additions or subtractions. The subgraph is not described by an opcode. It is captured by a few truth tables that apply alike to every bit position.

- Each addition slot owns a propagate table and a generate table. At each bit these give the p/g pair for that addition.
- A parallel-prefix network turns the p/g pairs into carries.
- Each subgraph output owns an output table. It is indexed at bit i by bit i of every operand and by the carry entering bit i of every addition.

A control engine fills the tables through a word-wide load port. The engine works out the table contents from the subgraph's instructions. After loading, the unit accepts an operand set with a valid strobe. It returns registered results with a valid strobe one clock later.

The second addition slot's tables also see the carry of the first slot at the same bit. So the two additions may be independent, chained, or separated by logic operations. A bit's output depends on lower operand bits only through the prefix carries. No ripple path runs from bit to bit.

Top module: `lut_carry_unit`

## Requirements
- R1: While reset is held and after its release, `out_valid` is 0 and `res_o` is 0 until the first input strobe.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 otherwise.
- R3: `res_o` is loaded only on a cycle with `in_valid` high and holds its value in every other cycle.
- R4: Result o, bit i, equals entry x of output table o. Bits 0..3 of x are bit i of operands 0..3, bit 4 is the carry into bit i of addition 0, and bit 5 is the carry into bit i of addition 1. Operand j is `op_i[32j+31:32j]` and result o is `res_o[32o+31:32o]`.
- R5: The carry into bit 0 of addition k is bit k of the carry-in field. This is 0 for an add and 1 for a subtract.
- R6: The carry into bit i+1 of addition k is g | (p & c). Here c is the carry into bit i, and p and g are read from the slot's tables at bit i. Addition 0's tables (16 entries) are indexed by operand bits 0..3. Addition 1's tables (32 entries) add addition 0's carry into bit i as index bit 4.
- R7: Configuration fields are selected by `cfg_sel`: 0 and 1 are the p and g tables of addition 0, 2 and 3 those of addition 1, 4 and 5 output tables 0 and 1, and 6 the carry-in field. Each field takes the low bits of `cfg_data`. Tables configured as an add and a subtract yield `op0+op1` and `op2-op3` modulo 2^32.
- R8: With addition 1 fed by the sum of addition 0, a result equals `op0+op1+op2`, and logic applied to an intermediate sum (xor with op3) is reproduced.
- R9: A configuration write issued in the same cycle as `in_valid` is dropped.
- R10: A write with `cfg_sel` of 7 leaves the configuration unchanged.
- R11: An addition slot with all-zero p/g tables and carry-in 0 produces only zero carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Field selected by the write |
| cfg_data | input | 64 | Table or carry-in contents, low bits used |
| in_valid | input | 1 | Operand set valid |
| op_i | input | 128 | Four 32-bit operands, operand 0 lowest |
| out_valid | output | 1 | Results valid, one cycle after `in_valid` |
| res_o | output | 64 | Two 32-bit results, result 0 lowest |

## Verification
The bench builds the unit with its default shape: 32-bit operands, four inputs, two addition slots and two outputs. This shape brings the dependent-addition indexing within reach. It also covers the full 64-entry output table and both subtract carry-in settings. Random table contents are compared against a bit-serial ripple model of the tables, so every prefix level is exercised against carries that travel the full word. Directed tables encoding real adds, subtracts and a chained sum check the arithmetic meaning at the 32-bit wrap.

// File: rtl/lcu_pkg.sv
package lcu_pkg;

  // Number of configuration fields: p/g per addition, one per output, carry-ins.
  function automatic int fld_count(input int nadd, input int nout);
    return 2 * nadd + nout + 1;
  endfunction

  // Entries in an output table.
  function automatic int out_entries(input int nin, input int nadd);
    return 1 << (nin + nadd);
  endfunction

  // Offset of the first output table inside the flat configuration vector.
  function automatic int out_base(input int nin, input int nadd);
    return 2 * ((1 << (nin + nadd)) - (1 << nin));
  endfunction

  // Width of configuration field f.
  function automatic int fld_w(input int nin, input int nadd, input int nout, input int f);
    if (f < 2 * nadd) return 1 << (nin + f / 2);
    else if (f < 2 * nadd + nout) return out_entries(nin, nadd);
    else return nadd;
  endfunction

  // Offset of configuration field f.
  function automatic int fld_off(input int nin, input int nadd, input int nout, input int f);
    if (f < 2 * nadd)
      return 2 * ((1 << (nin + f / 2)) - (1 << nin)) + (f % 2) * (1 << (nin + f / 2));
    else if (f < 2 * nadd + nout)
      return out_base(nin, nadd) + (f - 2 * nadd) * out_entries(nin, nadd);
    else
      return out_base(nin, nadd) + nout * out_entries(nin, nadd);
  endfunction

  // Total configuration width.
  function automatic int cfg_width(input int nin, input int nadd, input int nout);
    return out_base(nin, nadd) + nout * out_entries(nin, nadd) + nadd;
  endfunction

endpackage

// File: rtl/lcu_cfg_store.sv
module lcu_cfg_store
  import lcu_pkg::*;
#(
  parameter int NIN  = 4,
  parameter int NADD = 2,
  parameter int NOUT = 2,
  parameter int SELW = 3,
  parameter int DW   = 64,
  parameter int CFGW = 226
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [DW-1:0]   cfg_data,
  input  logic            in_valid,
  output logic [CFGW-1:0] cfg_o
);

  localparam int NFLD = fld_count(NADD, NOUT);

  // A compute strobe has priority: a write in the same cycle is dropped.
  logic wr_ok;
  assign wr_ok = cfg_we & ~in_valid;

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    localparam int FW = fld_w(NIN, NADD, NOUT, f);
    localparam int FO = fld_off(NIN, NADD, NOUT, f);

    logic [FW-1:0] fld_q;
    logic [FW-1:0] fld_d;
    logic          hit;

    assign hit = wr_ok && (cfg_sel == SELW'(f));

    always_comb begin
      fld_d = fld_q;
      if (hit) fld_d = cfg_data[FW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fld_q <= '0;
      else        fld_q <= fld_d;
    end

    assign cfg_o[FO +: FW] = fld_q;
  end

endmodule

// File: rtl/lcu_prefix.sv
module lcu_prefix #(
  parameter int N = 31
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  input  logic         cin_i,
  output logic [N:0]   carry_o
);

  localparam int LV = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] gl [LV+1];
  logic [N-1:0] pl [LV+1];

  assign gl[0] = g_i;
  assign pl[0] = p_i;

  // Kogge-Stone levels: span doubles each level.
  for (genvar s = 0; s < LV; s++) begin : g_lvl
    localparam int D = 1 << s;
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i >= D) begin : g_comb
        assign gl[s+1][i] = gl[s][i] | (pl[s][i] & gl[s][i-D]);
        assign pl[s+1][i] = pl[s][i] & pl[s][i-D];
      end else begin : g_pass
        assign gl[s+1][i] = gl[s][i];
        assign pl[s+1][i] = pl[s][i];
      end
    end
  end

  // carry_o[i] is the carry entering bit i; bit 0 takes the chain's carry-in.
  assign carry_o[0] = cin_i;
  for (genvar i = 0; i < N; i++) begin : g_out
    assign carry_o[i+1] = gl[LV][i] | (pl[LV][i] & cin_i);
  end

endmodule

// File: rtl/lcu_chain.sv
module lcu_chain #(
  parameter int WIDTH = 32,
  parameter int IW    = 4
) (
  input  logic [(WIDTH-1)*IW-1:0] idx_i,
  input  logic [(1<<IW)-1:0]      ptbl_i,
  input  logic [(1<<IW)-1:0]      gtbl_i,
  input  logic                    cin_i,
  output logic [WIDTH-1:0]        carry_o
);

  localparam int NB = WIDTH - 1;

  logic [NB-1:0] p_bit;
  logic [NB-1:0] g_bit;

  // Only bits 0..WIDTH-2 feed a higher bit; the top carry-out is never formed.
  for (genvar i = 0; i < NB; i++) begin : g_lkp
    assign p_bit[i] = ptbl_i[idx_i[i*IW +: IW]];
    assign g_bit[i] = gtbl_i[idx_i[i*IW +: IW]];
  end

  lcu_prefix #(.N(NB)) u_pfx (
    .p_i     (p_bit),
    .g_i     (g_bit),
    .cin_i   (cin_i),
    .carry_o (carry_o)
  );

endmodule

// File: rtl/lut_carry_unit.sv
module lut_carry_unit
  import lcu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int NIN   = 4,
  parameter int NADD  = 2,
  parameter int NOUT  = 2,
  localparam int OIW  = NIN + NADD,
  localparam int TW   = 1 << OIW,
  localparam int NFLD = fld_count(NADD, NOUT),
  localparam int SELW = $clog2(NFLD),
  localparam int CFGW = cfg_width(NIN, NADD, NOUT)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [SELW-1:0]       cfg_sel,
  input  logic [TW-1:0]         cfg_data,
  input  logic                  in_valid,
  input  logic [NIN*WIDTH-1:0]  op_i,
  output logic                  out_valid,
  output logic [NOUT*WIDTH-1:0] res_o
);

  localparam int CINO = fld_off(NIN, NADD, NOUT, NFLD - 1);

  logic [CFGW-1:0]  cfg_flat;
  logic [WIDTH-1:0] cin_bits [NADD];

  lcu_cfg_store #(
    .NIN(NIN), .NADD(NADD), .NOUT(NOUT), .SELW(SELW), .DW(TW), .CFGW(CFGW)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_data (cfg_data),
    .in_valid (in_valid),
    .cfg_o    (cfg_flat)
  );

  // Carry chains: chain k indexes its tables with operands and earlier carries.
  for (genvar k = 0; k < NADD; k++) begin : g_add
    localparam int IW = NIN + k;
    localparam int PW = 1 << IW;
    localparam int PO = fld_off(NIN, NADD, NOUT, 2 * k);
    localparam int GO = fld_off(NIN, NADD, NOUT, 2 * k + 1);

    logic [(WIDTH-1)*IW-1:0] idx;

    for (genvar i = 0; i < WIDTH - 1; i++) begin : g_bit
      for (genvar j = 0; j < NIN; j++) begin : g_op
        assign idx[i*IW + j] = op_i[j*WIDTH + i];
      end
      for (genvar m = 0; m < k; m++) begin : g_prev
        assign idx[i*IW + NIN + m] = cin_bits[m][i];
      end
    end

    lcu_chain #(.WIDTH(WIDTH), .IW(IW)) u_chain (
      .idx_i   (idx),
      .ptbl_i  (cfg_flat[PO +: PW]),
      .gtbl_i  (cfg_flat[GO +: PW]),
      .cin_i   (cfg_flat[CINO + k]),
      .carry_o (cin_bits[k])
    );
  end

  // Output table index per bit: operand bits, then carries entering that bit.
  logic [OIW-1:0] oidx [WIDTH];
  for (genvar i = 0; i < WIDTH; i++) begin : g_oidx
    for (genvar j = 0; j < NIN; j++) begin : g_op
      assign oidx[i][j] = op_i[j*WIDTH + i];
    end
    for (genvar m = 0; m < NADD; m++) begin : g_cy
      assign oidx[i][NIN + m] = cin_bits[m][i];
    end
  end

  for (genvar o = 0; o < NOUT; o++) begin : g_res
    localparam int OO = fld_off(NIN, NADD, NOUT, 2 * NADD + o);

    logic [TW-1:0]    tbl;
    logic [WIDTH-1:0] val;
    logic [WIDTH-1:0] res_q;
    logic [WIDTH-1:0] res_d;

    assign tbl = cfg_flat[OO +: TW];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign val[i] = tbl[oidx[i]];
    end

    always_comb begin
      res_d = res_q;
      if (in_valid) res_d = val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) res_q <= '0;
      else        res_q <= res_d;
    end

    assign res_o[o*WIDTH +: WIDTH] = res_q;
  end

  logic valid_q;
  logic valid_d;

  always_comb valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign out_valid = valid_q;

endmodule

// File: rtl/lcu_checker.sv
module lcu_checker #(
  parameter int RW   = 64,
  parameter int CW   = 226,
  parameter int SELW = 3,
  parameter int NFLD = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [SELW-1:0] cfg_sel,
  input logic            in_valid,
  input logic            out_valid,
  input logic [RW-1:0]   res_o,
  input logic [CW-1:0]   cfg_flat
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) a_r1_idle_in_reset: assert (!out_valid);
  end

  // R2
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  a_r2_no_extra_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3
  a_r3_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_o));

  // R9
  a_r9_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && in_valid) |=> $stable(cfg_flat));

  // R10
  a_r10_bad_select: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel >= SELW'(NFLD))) |=> $stable(cfg_flat));

endmodule

bind lut_carry_unit lcu_checker #(
  .RW(NOUT*WIDTH), .CW(CFGW), .SELW(SELW), .NFLD(NFLD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .res_o     (res_o),
  .cfg_flat  (cfg_flat)
);

// File: tb/lut_carry_unit_tb.sv
module lut_carry_unit_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         cfg_we;
  logic [2:0]   cfg_sel;
  logic [63:0]  cfg_data;
  logic         in_valid;
  logic [127:0] op;
  logic         out_valid;
  logic [63:0]  res;

  lut_carry_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .in_valid  (in_valid),
    .op_i      (op),
    .out_valid (out_valid),
    .res_o     (res)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench copy of the tables, kept from the requirements.
  logic [15:0] m_p0, m_g0;
  logic [31:0] m_p1, m_g1;
  logic [63:0] m_o0, m_o1;
  logic [1:0]  m_cin;

  localparam int K_ADD_P = 0, K_ADD_G = 1, K_SUB_P = 2, K_SUB_G = 3,
                 K_SUM0 = 4, K_DIF1 = 5, K_DEP_P = 6, K_DEP_G = 7,
                 K_SXD = 8, K_SUM2 = 9, K_C0 = 10, K_C0C1 = 11, K_ZERO = 12;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // Table entry x: bit0..3 operands, bit4 carry of add 0, bit5 carry of add 1.
  function automatic logic [63:0] build(input int kind);
    logic [63:0] t;
    for (int x = 0; x < 64; x++) begin
      logic a, b, c, d, c0, c1, s;
      a = x[0]; b = x[1]; c = x[2]; d = x[3]; c0 = x[4]; c1 = x[5];
      s = a ^ b ^ c0;
      case (kind)
        K_ADD_P: t[x] = a ^ b;
        K_ADD_G: t[x] = a & b;
        K_SUB_P: t[x] = c ^ ~d;
        K_SUB_G: t[x] = c & ~d;
        K_SUM0:  t[x] = s;
        K_DIF1:  t[x] = c ^ ~d ^ c1;
        K_DEP_P: t[x] = s ^ c;
        K_DEP_G: t[x] = s & c;
        K_SXD:   t[x] = s ^ d;
        K_SUM2:  t[x] = s ^ c ^ c1;
        K_C0:    t[x] = c0;
        K_C0C1:  t[x] = c0 | c1;
        default: t[x] = 1'b0;
      endcase
    end
    return t;
  endfunction

  // Bit-serial ripple evaluation of the stored tables.
  function automatic logic [63:0] model(input logic [127:0] ops);
    logic c0, c1, n0, n1;
    logic [31:0] r0, r1;
    c0 = m_cin[0];
    c1 = m_cin[1];
    for (int i = 0; i < 32; i++) begin
      logic [5:0] x;
      x = {c1, c0, ops[96+i], ops[64+i], ops[32+i], ops[i]};
      r0[i] = m_o0[x];
      r1[i] = m_o1[x];
      n0 = m_g0[x[3:0]] | (m_p0[x[3:0]] & c0);
      n1 = m_g1[x[4:0]] | (m_p1[x[4:0]] & c1);
      c0 = n0;
      c1 = n1;
    end
    return {r1, r0};
  endfunction

  task automatic raw_write(input logic [2:0] sel, input logic [63:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input logic [2:0] sel, input logic [63:0] data);
    raw_write(sel, data);
    case (sel)
      3'd0: m_p0 = data[15:0];
      3'd1: m_g0 = data[15:0];
      3'd2: m_p1 = data[31:0];
      3'd3: m_g1 = data[31:0];
      3'd4: m_o0 = data;
      3'd5: m_o1 = data;
      3'd6: m_cin = data[1:0];
      default: ;
    endcase
  endtask

  task automatic run(input logic [127:0] ops, input string req, output logic [63:0] got);
    logic [63:0] exp;
    logic [63:0] held;
    @(negedge clk);
    in_valid = 1'b1; op = ops;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(ops);
    check({req, " valid (R2)"}, {63'd0, out_valid}, 64'd1);
    check(req, res, exp);
    got = res;
    held = res;
    op = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    check("R2 valid drops", {63'd0, out_valid}, 64'd0);
    check("R3 result held", res, held);
  endtask

  function automatic logic [127:0] pack(input logic [31:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] got;
    logic [31:0] a, b, c, d;
    void'($urandom(32'h1a2b3c4d));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0; in_valid = 1'b0; op = '0;
    m_p0 = '0; m_g0 = '0; m_p1 = '0; m_g1 = '0; m_o0 = '0; m_o1 = '0; m_cin = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", res, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", {63'd0, out_valid}, 64'd0);
    check("R1 result after release", res, 64'd0);

    // R7: add in slot 0, subtract in slot 1.
    set_cfg(3'd0, build(K_ADD_P)); set_cfg(3'd1, build(K_ADD_G));
    set_cfg(3'd2, build(K_SUB_P)); set_cfg(3'd3, build(K_SUB_G));
    set_cfg(3'd4, build(K_SUM0));  set_cfg(3'd5, build(K_DIF1));
    set_cfg(3'd6, 64'd2);
    run(pack(32'hFFFF_FFFF, 32'h1, 32'h0, 32'h1), "R7 add/sub wrap", got);
    check("R7 sum wrap", {32'd0, got[31:0]}, 64'd0);
    check("R7 diff wrap", {32'd0, got[63:32]}, 64'hFFFF_FFFF);
    for (int n = 0; n < 20; n++) begin
      a = $urandom; b = $urandom; c = $urandom; d = $urandom;
      run(pack(a, b, c, d), "R7 add/sub", got);
      check("R7 arithmetic", got, {c - d, a + b});
    end

    // R9: write issued together with a compute strobe is dropped.
    a = 32'h7FFF_FFFF; b = 32'h1; c = 32'h5; d = 32'h9;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd4; cfg_data = build(K_C0);
    in_valid = 1'b1; op = pack(a, b, c, d);
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check("R9 result with colliding write", res, {c - d, a + b});
    run(pack(a, 32'h3, c, d), "R9 table kept", got);
    check("R9 arithmetic after dropped write", got, {c - d, a + 32'h3});

    // R10: select 7 changes nothing.
    raw_write(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    run(pack(32'h1234, 32'h4321, 32'h10, 32'h20), "R10 select 7", got);
    check("R10 arithmetic unchanged", got, {32'h10 - 32'h20, 32'h5555});

    // R8: slot 1 consumes slot 0's sum; logic on the intermediate sum.
    set_cfg(3'd2, build(K_DEP_P)); set_cfg(3'd3, build(K_DEP_G));
    set_cfg(3'd4, build(K_SXD));   set_cfg(3'd5, build(K_SUM2));
    set_cfg(3'd6, 64'd0);
    for (int n = 0; n < 20; n++) begin
      a = $urandom; b = $urandom; c = $urandom; d = $urandom;
      run(pack(a, b, c, d), "R8 chained", got);
      check("R8 chained arithmetic", got, {a + b + c, (a + b) ^ d});
    end
    run(pack(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h2, 32'h0), "R8 chained wrap", got);
    check("R8 chained wrap", got, {32'h0, 32'hFFFF_FFFE});

    // R11 and R5: zero p/g tables; carries only from carry-in at bit 0.
    set_cfg(3'd0, build(K_ZERO)); set_cfg(3'd1, build(K_ZERO));
    set_cfg(3'd2, build(K_ZERO)); set_cfg(3'd3, build(K_ZERO));
    set_cfg(3'd4, build(K_C0C1)); set_cfg(3'd5, build(K_C0));
    run({$urandom, $urandom, $urandom, $urandom}, "R11 zero slots", got);
    check("R11 no carries", got, 64'd0);
    set_cfg(3'd6, 64'd3);
    run({$urandom, $urandom, $urandom, $urandom}, "R5 carry-in", got);
    check("R5 carry into bit 0", got, 64'h0000_0001_0000_0001);
    set_cfg(3'd6, 64'd2);
    set_cfg(3'd5, build(K_C0C1)); set_cfg(3'd4, build(K_C0));
    run({$urandom, $urandom, $urandom, $urandom}, "R5 slot 1 carry-in", got);
    check("R5 per-slot carry-in", got, 64'h0000_0001_0000_0000);

    // R4, R6: random tables against the ripple model.
    for (int cfgn = 0; cfgn < 15; cfgn++) begin
      for (int s = 0; s < 7; s++) set_cfg(3'(s), {$urandom, $urandom});
      for (int n = 0; n < 8; n++)
        run({$urandom, $urandom, $urandom, $urandom}, "R4 R6 random tables", got);
      run(pack(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF), "R6 all ones", got);
      run('0, "R4 all zeros", got);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule